// File: doc/BRIEF.md
# Cycle Counter with Compare Timers

This block keeps a free-running cycle count and compares it against a small set of compare registers (zero to three). When the count reaches a compare value, the comparator gives a one-cycle timer pulse and sets its bit in a pending-interrupt vector. Each comparator is tied at build time to one interrupt number. Software sees a simple register port. One select value reads the live count. The other select values read or write the compare registers. Writing a compare register reloads it and also acknowledges that comparator's interrupt.

The count advances by one for each step the core reports. The match is found as the new count equalling the compare value, so it follows the counter through wraparound without any special case. A wake output tells a halted core that at least one timer interrupt is pending. Interrupt priority and clock generation are left to surrounding logic.

Top module: `cc_timer`

## Requirements
- R1: After a synchronous active-low reset, the count is zero, every compare register reads zero, the pending vector is zero and every timer pulse is low.
- R2: The count rises by exactly one, modulo 2^CNT_W, at each clock edge where `step_en` is high, and holds where it is low.
- R3: `rd_data` is combinational. Select 3 returns the current count. Selects 0 to 2 return that compare register, and a select for a slot at or beyond NUM_CMP returns zero.
- R4: `tmr_pulse[i]` is high for exactly one cycle: the first cycle in which the count, after a step, equals compare register i.
- R5: Pending bit MAP_i is set in the same cycle as that pulse. It stays set until compare register i is written.
- R6: A write to compare register i stores `wr_data` and clears pending bit MAP_i by the next cycle. If the write falls in the cycle that would have produced a match, there is no pulse and the bit is not set.
- R7: A compare value that the count has already passed fires only after the counter wraps through zero back to that value.
- R8: A write with select 3, or with a select for a slot at or beyond NUM_CMP, changes nothing: the count and every compare read keep their values.
- R9: `wake` is high exactly when `halted` is high and at least one pending bit is set.
- R10: Comparators work independently. Two compare registers holding the same value pulse in the same cycle and set both of their mapped bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance the count by one this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select (0..2 compare slots, 3 count) |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Read select (0..2 compare slots, 3 count) |
| rd_data | output | CNT_W | Read data for `rd_sel` |
| halted | input | 1 | Core is halted waiting for an interrupt |
| tmr_pulse | output | 3 | One-cycle match pulse per comparator slot |
| irq_pend | output | NUM_IRQ | Pending timer interrupt bits |
| wake | output | 1 | Wake request to a halted core |

## Verification
The bench builds two copies. The first is the full build: three comparators, a 32-bit count and interrupt numbers 0, 3 and 6. It covers the match timing, the write that collides with a match, two comparators firing together, and the wake logic. The second copy has two comparators, an 8-bit count and interrupt numbers 5 and 1. Its short counter lets a compare value that has already been passed wrap around within a few hundred cycles. Its missing third slot shows that writes to an unbuilt comparator are dropped and that reads of it return zero.

// File: rtl/ccmp_pkg.sv
// Shared constants for the cycle counter / compare timer block.
// Assumes a 2-bit register select: slots 0..2 are compare registers,
// select 3 is the live count.
package ccmp_pkg;
    localparam int              SEL_W     = 2;
    localparam int              MAX_CMP   = 3;
    localparam logic [SEL_W-1:0] SEL_COUNT = 2'd3;
endpackage

// File: rtl/cc_counter.sv
// Free-running step counter.
// Assumes step_en is at most one step per clock; wraps modulo 2^CNT_W.
module cc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Advance the count on each reported step.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (step_en) cnt_q <= cnt_q + ONE;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(cnt_q)); // R2
    AST_CNT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (cnt_q == CNT_W'($past(cnt_q) + ONE))); // R2
endmodule

// File: rtl/cc_slot.sv
// One compare slot: holds a compare value and flags the step that brings
// the count onto it. Equality with the next count is wrap-safe because
// the count moves by one per step. A write in the match cycle suppresses it.
module cc_slot #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cmp_q,
    output logic             hit,
    output logic             pulse_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    logic [CNT_W-1:0] cnt_next;

    // Count value after this cycle's step.
    assign cnt_next = cnt_q + ONE;
    // Match on the step landing on the compare value, unless being rewritten.
    assign hit = step_en && !wr_en && (cnt_next == cmp_q);

    // Compare register reload.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmp_q <= '0;
        else if (wr_en) cmp_q <= wr_data;
    end

    // Pulse in the cycle the count shows the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= hit;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R4
    AST_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !pulse_q); // R6
endmodule

// File: rtl/cc_pending.sv
// Pending timer interrupt bits: set by comparator matches, cleared by
// compare writes. Clear takes precedence over set for the same bit.
module cc_pending #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_v,
    input  logic [NUM_IRQ-1:0] clr_v,
    output logic [NUM_IRQ-1:0] pend_q
);
    // Update pending bits from matches and acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | set_v) & ~clr_v;
    end

    for (genvar b = 0; b < NUM_IRQ; b++) begin : g_chk
        AST_PEND_ONLY_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[b]) |-> $past(set_v[b])); // R5
    end
endmodule

// File: rtl/cc_timer.sv
// Cycle counter with up to three compare timers, a register read/write
// port and a wake request. Assumes MAP0..MAP2 are distinct and below
// NUM_IRQ, and NUM_CMP is 0..3. Select 3 is the live count (read only).
module cc_timer #(
    parameter int CNT_W   = 32,
    parameter int NUM_CMP = 3,
    parameter int NUM_IRQ = 8,
    parameter int MAP0    = 0,
    parameter int MAP1    = 3,
    parameter int MAP2    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [1:0]         rd_sel,
    output logic [CNT_W-1:0]   rd_data,
    input  logic               halted,
    output logic [2:0]         tmr_pulse,
    output logic [NUM_IRQ-1:0] irq_pend,
    output logic               wake
);
    import ccmp_pkg::*;

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cmp_q [MAX_CMP];
    logic [MAX_CMP-1:0] hit;
    logic [MAX_CMP-1:0] wr_slot;
    logic [NUM_IRQ-1:0] set_v;
    logic [NUM_IRQ-1:0] clr_v;

    cc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .cnt_q(cnt_q)
    );

    for (genvar i = 0; i < MAX_CMP; i++) begin : g_slot
        localparam int M = (i == 0) ? MAP0 : (i == 1) ? MAP1 : MAP2;
        if (i < NUM_CMP) begin : g_on
            assign wr_slot[i] = wr_en && (wr_sel == SEL_W'(i));
            cc_slot #(.CNT_W(CNT_W)) u_slot (
                .clk(clk), .rst_n(rst_n), .step_en(step_en), .cnt_q(cnt_q),
                .wr_en(wr_slot[i]), .wr_data(wr_data), .cmp_q(cmp_q[i]),
                .hit(hit[i]), .pulse_q(tmr_pulse[i])
            );

            AST_PULSE_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
                tmr_pulse[i] |-> (cnt_q == cmp_q[i])); // R4
            AST_PULSE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
                tmr_pulse[i] |-> irq_pend[M]); // R5
            AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                wr_slot[i] |=> !irq_pend[M]); // R6
        end else begin : g_off
            assign wr_slot[i]   = 1'b0;
            assign cmp_q[i]     = '0;
            assign hit[i]       = 1'b0;
            assign tmr_pulse[i] = 1'b0;
        end
    end

    // Route each slot's match and acknowledge onto its interrupt number.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int i = 0; i < MAX_CMP; i++) begin
            int m;
            m = (i == 0) ? MAP0 : (i == 1) ? MAP1 : MAP2;
            if (i < NUM_CMP) begin
                set_v[m] = set_v[m] | hit[i];
                clr_v[m] = clr_v[m] | wr_slot[i];
            end
        end
    end

    cc_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .pend_q(irq_pend)
    );

    // Register read mux: count or a compare slot.
    always_comb begin
        if (rd_sel == SEL_COUNT) rd_data = cnt_q;
        else                     rd_data = cmp_q[rd_sel];
    end

    // Wake a halted core when any timer interrupt is pending.
    assign wake = halted && (|irq_pend);

    AST_WAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (halted && irq_pend != '0)); // R9
endmodule

// File: tb/cc_timer_test.sv
module cc_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd3;
    logic        halted = 1'b0;

    logic [31:0] rd_a;
    logic [2:0]  pul_a;
    logic [7:0]  pend_a;
    logic        wake_a;
    logic [7:0]  rd_b;
    logic [2:0]  pul_b;
    logic [7:0]  pend_b;
    logic        wake_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] m_cnt;   // expected count (both copies; B uses low 8 bits)

    always #4 clk = ~clk; // 125 MHz

    cc_timer uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_a),
        .halted(halted), .tmr_pulse(pul_a), .irq_pend(pend_a), .wake(wake_a)
    );

    cc_timer #(.CNT_W(8), .NUM_CMP(2), .NUM_IRQ(8), .MAP0(5), .MAP1(1), .MAP2(7)) uut_two (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data[7:0]), .rd_sel(rd_sel), .rd_data(rd_b),
        .halted(halted), .tmr_pulse(pul_b), .irq_pend(pend_b), .wake(wake_b)
    );

    // Expected count, from R2.
    always @(posedge clk) begin
        if (!rst_n)       m_cnt <= '0;
        else if (step_en) m_cnt <= m_cnt + 32'd1;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_a_chk(string req, logic [1:0] sel, logic [31:0] exp);
        rd_sel = sel; #1;
        chk(req, "read uut", rd_a, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        rd_a_chk("R1", 2'd3, 32'd0);
        rd_a_chk("R1", 2'd0, 32'd0);
        rd_a_chk("R1", 2'd2, 32'd0);
        chk("R1", "pend", {24'd0, pend_a}, 32'd0);
        chk("R1", "pulse", {29'd0, pul_a}, 32'd0);
        chk("R1", "pend two", {24'd0, pend_b}, 32'd0);
    endtask

    task automatic t_count();
        logic [31:0] held;
        repeat (5) begin
            @(negedge clk);
            rd_a_chk("R2", 2'd3, m_cnt);
        end
        step_en = 1'b0;
        @(negedge clk);
        held = m_cnt;
        repeat (4) @(negedge clk);
        rd_a_chk("R2", 2'd3, held);
        step_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_a_chk("R2", 2'd3, held + 32'd3);
        rd_sel = 2'd3; #1;
        chk("R3", "read uut_two count", {24'd0, rd_b}, {24'd0, m_cnt[7:0]});
    endtask

    task automatic t_match();
        logic [31:0] tgt;
        int seen;
        seen = 0;
        tgt = m_cnt + 32'd4;
        wr(2'd0, tgt);
        rd_a_chk("R6", 2'd0, tgt);
        for (int k = 0; k < 8; k++) begin
            if (m_cnt == tgt) begin
                seen++;
                chk("R4", "pulse at match", {31'd0, pul_a[0]}, 32'd1);
                chk("R5", "pend with pulse", {31'd0, pend_a[0]}, 32'd1);
            end else begin
                chk("R4", "no pulse off match", {31'd0, pul_a[0]}, 32'd0);
            end
            @(negedge clk);
        end
        chk("R4", "pulse count", seen, 1);
        chk("R5", "pend held", {31'd0, pend_a[0]}, 32'd1);
        wr(2'd0, m_cnt - 32'd1);
        chk("R6", "pend cleared", {31'd0, pend_a[0]}, 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] tgt;
        tgt = m_cnt + 32'd2;
        wr(2'd0, tgt);
        wr(2'd0, tgt);
        chk("R6", "count at tgt", m_cnt, tgt);
        chk("R6", "no pulse on collide", {31'd0, pul_a[0]}, 32'd0);
        chk("R6", "no pend on collide", {31'd0, pend_a[0]}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R6", "still no pend", {31'd0, pend_a[0]}, 32'd0);
    endtask

    task automatic t_wrap();
        logic [7:0] tgt;
        int seen;
        int miss;
        seen = 0; miss = 0;
        tgt = m_cnt[7:0] - 8'd2;
        wr(2'd1, {24'd0, tgt});
        chk("R6", "uut_two pend1 cleared", {31'd0, pend_b[1]}, 32'd0);
        for (int k = 0; k < 260; k++) begin
            if (m_cnt[7:0] == tgt) begin
                seen++;
                if (pul_b[1] !== 1'b1) miss++;
            end else if (pul_b[1] !== 1'b0) miss++;
            @(negedge clk);
        end
        chk("R7", "wrap pulse count", seen, 1);
        chk("R7", "wrap pulse mismatches", miss, 0);
        chk("R7", "wrap pend set", {31'd0, pend_b[1]}, 32'd1);
    endtask

    task automatic t_ignore();
        wr(2'd2, 32'hA5A5_0F0F);
        rd_a_chk("R3", 2'd2, 32'hA5A5_0F0F);
        rd_sel = 2'd2; #1;
        chk("R8", "unbuilt slot reads zero", {24'd0, rd_b}, 32'd0);
        wr(2'd3, 32'd0);
        rd_a_chk("R8", 2'd3, m_cnt);
        rd_a_chk("R8", 2'd2, 32'hA5A5_0F0F);
    endtask

    task automatic t_dual();
        logic [31:0] tgt;
        tgt = m_cnt + 32'd10;
        wr(2'd0, tgt);
        wr(2'd2, tgt);
        while (m_cnt != tgt) @(negedge clk);
        chk("R10", "both pulses", {29'd0, pul_a}, {29'd0, 3'b101} & {29'd0, pul_a | 3'b101});
        chk("R10", "pulse0", {31'd0, pul_a[0]}, 32'd1);
        chk("R10", "pulse2", {31'd0, pul_a[2]}, 32'd1);
        chk("R10", "pend bits 0 and 6", {30'd0, pend_a[6], pend_a[0]}, 32'd3);
    endtask

    task automatic t_wake();
        halted = 1'b1; #1;
        chk("R9", "wake with pend", {31'd0, wake_a}, 32'd1);
        halted = 1'b0; #1;
        chk("R9", "no wake when running", {31'd0, wake_a}, 32'd0);
        @(negedge clk);
        wr(2'd0, m_cnt - 32'd1);
        wr(2'd1, m_cnt - 32'd1);
        wr(2'd2, m_cnt - 32'd1);
        chk("R6", "all pend cleared", {24'd0, pend_a}, 32'd0);
        halted = 1'b1; #1;
        chk("R9", "no wake without pend", {31'd0, wake_a}, 32'd0);
        halted = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_count();
        t_match();
        t_collide();
        t_wrap();
        t_ignore();
        t_dual();
        t_wake();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule